// File: doc/BRIEF.md
# Seven-Source Two-Level Interrupt Arbiter

This block sits beside a small CPU core and decides which of seven interrupt requests the core should take next. The request inputs come, in a fixed polling order, from two external pins, two timer overflows, a combined serial transmit/receive flag, an A/D conversion-complete flag and a watchdog overflow. Each source can be enabled on its own, and a global enable gates them all. A per-source priority bit places every source in either the high or the low level.

The arbiter presents a request line, a 16-bit vector address and the index of the chosen source. It tracks which levels are in service, using one bit per level. A high-level request may interrupt a low-level handler. A request at the same level as the active handler, or at a lower level, waits until the CPU signals a return. The watchdog source counts only while the watchdog runs as a plain timer; in its reset mode its overflow is disregarded.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable register reads 00h, the priority register reads 00h, both in-service bits are clear and no request is offered.
- R2: Source index order is INT0=0, timer0=1, INT1=2, timer1=3, serial=4, A/D=5, watchdog=6. Enable bit i (0..6) enables source i and enable bit 7 is the global enable. Priority bit i (0..6) set puts source i in the high level. Priority bit 7 is not stored and reads 0. Both registers take their write data at the clock edge of a write strobe.
- R3: A source is eligible only when its request, its enable bit and the global enable bit are all 1. With the global enable at 0 no request is offered, whatever the individual enables.
- R4: The watchdog source (index 6) is treated as not requesting while the watchdog-timer-mode input is 0.
- R5: Among eligible sources of one level, the one with the lowest index is chosen.
- R6: An offerable high-level source is chosen ahead of any low-level source, whatever the indices.
- R7: The outputs follow the current inputs and register state in the same cycle. While a request is offered, the vector is 0003h + 8 × index, the source output is the index and the level output is that source's priority bit. With no request offered, all three are 0.
- R8: An acknowledge strobe taken while a request is offered sets the in-service bit of the offered level. An acknowledge strobe with no request offered changes nothing.
- R9: While the low in-service bit alone is set, only high-level sources are offered. While the high in-service bit is set, nothing is offered.
- R10: A return strobe clears the high in-service bit if it is set, and otherwise the low one. With neither set, the strobe has no effect.
- R11: When acknowledge and return strobes arrive in the same cycle, both act on the state before the edge. The return clears the highest set bit and the acknowledge sets the bit of the offered level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 7 | Request flags, bit i = source index i |
| wdt_timer_mode_i | input | 1 | 1 = watchdog runs as timer, its overflow may interrupt |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| pri_we_i | input | 1 | Priority register write strobe |
| pri_wdata_i | input | 8 | Priority register write data (bit 7 ignored) |
| ack_i | input | 1 | CPU acknowledge strobe |
| reti_i | input | 1 | CPU return-from-interrupt strobe |
| en_q_o | output | 8 | Enable register contents |
| pri_q_o | output | 8 | Priority register contents, bit 7 reads 0 |
| irq_o | output | 1 | Request offered to the CPU |
| lvl_o | output | 1 | Level of the offered request (1 = high) |
| src_o | output | 3 | Index of the offered source |
| vec_o | output | 16 | Vector address of the offered source |
| insvc_o | output | 2 | In-service bits, bit 1 = high level, bit 0 = low level |

## Verification
The acknowledge and the return strobe can coincide. A low-level handler is active while a high-level source is offered, so one edge must both clear the low in-service bit and set the high one. The bench sets this up directly: it acknowledges a low source, raises a high request, and pulses both strobes together. It expects the in-service pair to read 10b afterwards. The random phase also fires both strobes independently at moderate rates. Every such edge is compared against a model that applies the clear and the set to the state before the edge.

// File: rtl/prio_irq_pkg.sv
// Shared constants and types for the two-level interrupt arbiter.
// Assumes source indices double as polling order (0 = polled first).
package prio_irq_pkg;
    localparam int          NSRC_DEF  = 7;
    localparam int          WDT_DEF   = 6;
    localparam logic [15:0] VEC_BASE  = 16'h0003;
    localparam logic [15:0] VEC_STEP  = 16'd8;
    localparam int          NLVL      = 2;

    // One arbitration decision.
    typedef struct packed {
        logic       valid;
        logic       lvl;
        logic [2:0] idx;
    } pick_t;
endpackage

// File: rtl/irq_cfg_regs.sv
// Enable and priority registers of the arbiter.
// Enable register: NSRC per-source bits plus a global bit at index NSRC.
// Priority register: NSRC bits; the top bit of the write bus is discarded.
// Assumes writes are single-cycle strobes with data valid alongside.
module irq_cfg_regs #(
    parameter int NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic [NSRC:0]   en_wdata,
    input  logic            pri_we,
    input  logic [NSRC:0]   pri_wdata,
    output logic [NSRC:0]   en_q,
    output logic [NSRC-1:0] pri_q
);
    // Enable register: load on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_we)
            en_q <= en_wdata;
    end

    // Priority register: keep only the per-source bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pri_q <= '0;
        else if (pri_we)
            pri_q <= pri_wdata[NSRC-1:0];
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_we) && $past(rst_n) |-> $stable(en_q)); // R2
endmodule

// File: rtl/irq_first_pick.sv
// Finds the lowest set bit of a request vector (fixed polling order).
// Purely combinational; assumes IW is wide enough to hold N-1.
module irq_first_pick #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the last index down so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_nest.sv
// In-service tracking for two priority levels.
// Bit 1 = high level active, bit 0 = low level active.
// Assumes the caller only raises take for a level that may be entered.
module irq_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_lvl,
    input  logic       reti,
    output logic [1:0] insvc
);
    logic [1:0] clr_mask;
    logic [1:0] set_mask;

    // Return clears the highest set in-service bit.
    always_comb begin
        clr_mask = 2'b00;
        if (reti) begin
            if (insvc[1])      clr_mask = 2'b10;
            else if (insvc[0]) clr_mask = 2'b01;
        end
    end

    // Acknowledge marks the offered level as in service.
    always_comb begin
        set_mask = 2'b00;
        if (take) set_mask = take_lvl ? 2'b10 : 2'b01;
    end

    // Apply clear and set against the pre-edge state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            insvc <= 2'b00;
        else
            insvc <= (insvc & ~clr_mask) | set_mask;
    end

    AST_ACK_SETS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_lvl) |=> insvc[1]); // R8
    AST_ACK_SETS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !take_lvl) |=> insvc[0]); // R8
    AST_RETI_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && insvc[1] && !take) |=> !insvc[1]); // R10
    AST_IDLE_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && insvc == 2'b00 && !take) |=> insvc == 2'b00); // R10
    AST_LO_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(insvc[0]) |-> !insvc[1]); // R9
endmodule

// File: rtl/prio_irq_ctrl.sv
// Two-level, seven-source vectored interrupt arbiter.
// Qualifies requests with enables, picks the first eligible source of the
// highest enterable level, produces its vector, and tracks nesting.
// Outputs are combinational from inputs and state; assumes the CPU
// samples them in the cycle it raises ack_i.
module prio_irq_ctrl #(
    parameter int NSRC    = prio_irq_pkg::NSRC_DEF,
    parameter int WDT_IDX = prio_irq_pkg::WDT_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic          wdt_timer_mode_i,
    input  logic          en_we_i,
    input  logic [NSRC:0] en_wdata_i,
    input  logic          pri_we_i,
    input  logic [NSRC:0] pri_wdata_i,
    input  logic          ack_i,
    input  logic          reti_i,
    output logic [NSRC:0] en_q_o,
    output logic [NSRC:0] pri_q_o,
    output logic          irq_o,
    output logic          lvl_o,
    output logic [2:0]    src_o,
    output logic [15:0]   vec_o,
    output logic [1:0]    insvc_o
);
    import prio_irq_pkg::*;

    localparam int IW = 3;

    logic [NSRC:0]   en_q;
    logic [NSRC-1:0] pri_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] hi_cand;
    logic [NSRC-1:0] lo_cand;
    logic            hi_found;
    logic            lo_found;
    logic [IW-1:0]   hi_idx;
    logic [IW-1:0]   lo_idx;
    logic [1:0]      insvc;
    pick_t           sel;

    irq_cfg_regs #(.NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (en_we_i),
        .en_wdata  (en_wdata_i),
        .pri_we    (pri_we_i),
        .pri_wdata (pri_wdata_i),
        .en_q      (en_q),
        .pri_q     (pri_q)
    );

    // Per-source qualification; the watchdog slot also needs timer mode.
    for (genvar g = 0; g < NSRC; g++) begin : g_qual
        if (g == WDT_IDX) begin : g_wdt
            assign elig[g] = req_i[g] & en_q[g] & en_q[NSRC] & wdt_timer_mode_i;
        end else begin : g_std
            assign elig[g] = req_i[g] & en_q[g] & en_q[NSRC];
        end
    end

    assign hi_cand = elig & pri_q;
    assign lo_cand = elig & ~pri_q;

    irq_first_pick #(.N(NSRC), .IW(IW)) u_pick_hi (
        .cand  (hi_cand),
        .found (hi_found),
        .idx   (hi_idx)
    );

    irq_first_pick #(.N(NSRC), .IW(IW)) u_pick_lo (
        .cand  (lo_cand),
        .found (lo_found),
        .idx   (lo_idx)
    );

    // Level resolution against the in-service state.
    always_comb begin
        sel = '0;
        if (hi_found && !insvc[1]) begin
            sel.valid = 1'b1;
            sel.lvl   = 1'b1;
            sel.idx   = hi_idx;
        end else if (lo_found && insvc == 2'b00) begin
            sel.valid = 1'b1;
            sel.lvl   = 1'b0;
            sel.idx   = lo_idx;
        end
    end

    irq_nest u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (ack_i & sel.valid),
        .take_lvl (sel.lvl),
        .reti     (reti_i),
        .insvc    (insvc)
    );

    // Output drive: vector evenly spaced from the base.
    always_comb begin
        irq_o = sel.valid;
        lvl_o = sel.lvl;
        src_o = sel.idx;
        vec_o = sel.valid ? (VEC_BASE + 16'(sel.idx) * VEC_STEP) : 16'h0000;
    end

    assign en_q_o  = en_q;
    assign pri_q_o = {1'b0, pri_q};
    assign insvc_o = insvc;

    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q_o[NSRC] |-> !irq_o); // R3
    AST_WDT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_timer_mode_i && irq_o) |-> (src_o != 3'(WDT_IDX))); // R4
    AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_o[1] |-> !irq_o); // R9
    AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_o[0] && irq_o) |-> lvl_o); // R9
    AST_LVL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (lvl_o == pri_q_o[src_o])); // R7
    AST_REQ_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i[src_o] && en_q_o[src_o])); // R3
endmodule

// File: tb/prio_irq_ctrl_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared each cycle with a reference model built from the requirements.
module prio_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  req;
    logic        wmode, en_we, pri_we, ack, reti;
    logic [7:0]  en_wd, pri_wd, en_q, pri_q;
    logic        irq, lvl;
    logic [2:0]  src;
    logic [15:0] vec;
    logic [1:0]  insvc;

    int checks = 0;
    int errors = 0;
    logic [7:0]  m_en, m_pri;
    logic [1:0]  m_ins;
    logic [20:0] last_out;
    int unsigned seed_val;

    always #10 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wdt_timer_mode_i(wmode),
        .en_we_i(en_we), .en_wdata_i(en_wd), .pri_we_i(pri_we),
        .pri_wdata_i(pri_wd), .ack_i(ack), .reti_i(reti),
        .en_q_o(en_q), .pri_q_o(pri_q), .irq_o(irq), .lvl_o(lvl),
        .src_o(src), .vec_o(vec), .insvc_o(insvc)
    );

    // Expected {irq, lvl, src, vec} from requirements R3-R7, R9.
    function automatic logic [20:0] model(input logic [6:0] r, input logic [7:0] e,
                                          input logic [7:0] p, input logic wm,
                                          input logic [1:0] ins);
        logic [6:0]  el;
        logic [20:0] o;
        el = r & e[6:0] & {7{e[7]}};
        if (!wm) el[6] = 1'b0;
        o = '0;
        if (!ins[1])
            for (int i = 6; i >= 0; i--)
                if (el[i] && p[i]) o = {1'b1, 1'b1, 3'(i), 16'h0003 + 16'(8 * i)};
        if (!o[20] && ins == 2'b00)
            for (int i = 6; i >= 0; i--)
                if (el[i] && !p[i]) o = {1'b1, 1'b0, 3'(i), 16'h0003 + 16'(8 * i)};
        return o;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before the edge, update model after.
    task automatic step(input logic [6:0] r, input logic a, input logic t,
                        input logic wm, input logic ew, input logic [7:0] ed,
                        input logic pw, input logic [7:0] pd);
        logic [20:0] exp;
        logic [1:0]  clr, set;
        @(negedge clk);
        req = r; ack = a; reti = t; wmode = wm;
        en_we = ew; en_wd = ed; pri_we = pw; pri_wd = pd;
        #5;
        last_out = {irq, lvl, src, vec};
        exp = model(r, m_en, m_pri, wm, m_ins);
        chk(last_out == exp, "R7 outputs (R5 R6)", 32'(last_out), 32'(exp));
        chk(insvc == m_ins, "R9 in-service", 32'(insvc), 32'(m_ins));
        chk({en_q, pri_q} == {m_en, m_pri}, "R2 registers", 32'({en_q, pri_q}),
            32'({m_en, m_pri}));
        @(posedge clk);
        clr = 2'b00;
        if (t) clr = m_ins[1] ? 2'b10 : (m_ins[0] ? 2'b01 : 2'b00);
        set = (a && exp[20]) ? (exp[19] ? 2'b10 : 2'b01) : 2'b00;
        m_ins = (m_ins & ~clr) | set;
        if (ew) m_en = ed;
        if (pw) m_pri = {1'b0, pd[6:0]};
        #1;
    endtask

    task automatic wr_en(input logic [7:0] d);
        step(7'h00, 1'b0, 1'b0, 1'b1, 1'b1, d, 1'b0, 8'h00);
    endtask

    task automatic wr_pri(input logic [7:0] d);
        step(7'h00, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, d);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd1234);
        rst_n = 1'b0; req = '0; wmode = 1'b0; en_we = 1'b0; pri_we = 1'b0;
        en_wd = '0; pri_wd = '0; ack = 1'b0; reti = 1'b0;
        m_en = '0; m_pri = '0; m_ins = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk({en_q, pri_q, insvc, irq} == 19'h0, "R1 reset state",
            32'({en_q, pri_q, insvc, irq}), 32'h0);

        // R3: individual enables without global give nothing
        wr_en(8'h7F);
        step(7'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out[20] == 1'b0, "R3 global mask", 32'(last_out[20]), 32'h0);
        wr_en(8'hFF);

        // R4: watchdog ignored in reset mode, served in timer mode
        step(7'h40, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out[20] == 1'b0, "R4 watchdog in reset mode", 32'(last_out), 32'h0);
        step(7'h40, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out == {1'b1, 1'b0, 3'd6, 16'h0033}, "R4 watchdog in timer mode",
            32'(last_out), 32'({1'b1, 1'b0, 3'd6, 16'h0033}));

        // R5: lowest index wins within a level
        step(7'h34, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out[18:0] == {3'd2, 16'h0013}, "R5 polling order",
            32'(last_out[18:0]), 32'({3'd2, 16'h0013}));

        // R6: a high-level source beats lower indices
        wr_pri(8'h20);
        step(7'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out == {1'b1, 1'b1, 3'd5, 16'h002B}, "R6 high level first",
            32'(last_out), 32'({1'b1, 1'b1, 3'd5, 16'h002B}));

        // R2: priority bit 7 reads zero
        wr_pri(8'hFF);
        chk(pri_q == 8'h7F, "R2 priority bit 7", 32'(pri_q), 32'h7F);

        // R8: acknowledge with nothing offered is ignored
        wr_pri(8'h08);
        step(7'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(insvc == 2'b00, "R8 ack without request", 32'(insvc), 32'h0);

        // R8/R9: nesting sequence, timer1 high, INT0 low
        step(7'h01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(insvc == 2'b01, "R8 low ack", 32'(insvc), 32'h1);
        step(7'h03, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out[20] == 1'b0, "R9 low blocked under low", 32'(last_out), 32'h0);
        step(7'h08, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out == {1'b1, 1'b1, 3'd3, 16'h001B}, "R9 high preempts low",
            32'(last_out), 32'({1'b1, 1'b1, 3'd3, 16'h001B}));
        chk(insvc == 2'b11, "R8 high ack nested", 32'(insvc), 32'h3);
        step(7'h08, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(last_out[20] == 1'b0, "R9 nothing under high", 32'(last_out), 32'h0);

        // R10: returns unwind highest first, then no effect
        step(7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(insvc == 2'b01, "R10 clear high first", 32'(insvc), 32'h1);
        step(7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(insvc == 2'b00, "R10 clear low", 32'(insvc), 32'h0);
        step(7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(insvc == 2'b00, "R10 idle return", 32'(insvc), 32'h0);

        // R11: acknowledge and return in the same cycle
        step(7'h01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        step(7'h08, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);
        chk(insvc == 2'b10, "R11 ack and return together", 32'(insvc), 32'h2);
        step(7'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00);

        // Random traffic against the model (all requirements)
        for (int n = 0; n < 4000; n++) begin
            step(7'($urandom & $urandom), ($urandom % 3) == 0, ($urandom % 5) == 0,
                 1'($urandom), ($urandom % 25) == 0, 8'($urandom | 32'h80),
                 ($urandom % 25) == 0, 8'($urandom));
        end

        summary();
        $finish;
    end
endmodule